// File: doc/BRIEF.md
# Command Post and Completion Queue Registers

This block is the device-side register file of a storage controller's host interface. It sits behind a 32-bit memory-mapped slave port. The host posts command addresses by writing them into an inbound queue. It collects finished command tags by reading an outbound queue, where a read of an empty queue returns all ones. Controller logic on the device side drains the inbound queue and pushes completion tags, each with an error flag, into the outbound queue.

An interrupt line is raised while completions wait in the outbound queue or while an outbound doorbell is pending. Each interrupt source can be blocked by a mask register. The host can ring an inbound doorbell to say that the configuration table has changed, and that doorbell stays raised until the device acknowledges it. A parameter selects which interrupt status bit reports the not-empty condition, so that both board variants can be served.

Two small state machines carry the control. The access machine has two states. It moves from `ACC_IDLE` to `ACC_RESP` on any accepted read, and it stays in `ACC_RESP` only while reads arrive back to back. `ACC_RESP` drives the read-valid strobe. Each doorbell is a `cmdq_bell` machine with two states. It moves from `BELL_IDLE` to `BELL_PEND` on a set and from `BELL_PEND` back to `BELL_IDLE` on a clear. A clear wins over a set that arrives in the same cycle.

Top module: `cmdq_regblock`

## Requirements
- R1: A host write to offset 0x40 puts the written word into the 16-entry inbound queue. `dev_cmd_valid` is high while that queue holds data, and `dev_cmd_addr` shows its oldest entry. A one-cycle `dev_cmd_pop` moves to the next entry, in first-in, first-out order.
- R2: A host read of offset 0x44 with the outbound queue non-empty returns its oldest entry and removes that entry. Read data and `hst_rvalid` appear in the cycle after the request.
- R3: A host read of offset 0x44 with the outbound queue empty returns 0xFFFFFFFF and changes no state.
- R4: A completion pushed by `dev_cmp_push` is stored as `dev_cmp_tag` with bit 0 forced to 0 and bit 1 replaced by `dev_cmp_err`.
- R5: Offset 0x30 reads the raw interrupt status. Bit 0 is the outbound doorbell pending. The outbound-not-empty flag is at bit 3 when `NE_ALT`=0 and at bit 2 when `NE_ALT`=1. All other bits read 0.
- R6: Offset 0x34 is the read/write interrupt mask, and it resets to 0xFFFFFFFF. `irq` is high in the cycle after any status bit is 1 while its mask bit is 0.
- R7: Writing a word with bit 0 set to offset 0x20 raises `dev_cfg_update`, and that offset reads back with bit 0 set. Writing 0 there does not clear the flag. Only a one-cycle `dev_cfg_ack` clears it.
- R8: A one-cycle `dev_odb_set` sets the outbound doorbell pending. A host write to offset 0xA0 with bit 0 set clears it. A write there with bit 0 clear has no effect.
- R9: Offset 0x9C is read-only. Bits [7:0] hold the outbound queue occupancy, bits [15:8] hold the inbound queue occupancy, and bit 16 holds the outbound doorbell pending.
- R10: A host push to a full inbound queue is dropped and sets `dev_ipq_ovf`, which stays set until reset. A device push to a full outbound queue is dropped, and `dev_cmp_full` is high while that queue is full.
- R11: Reads of unmapped offsets return 0. Writes to offsets 0x30, 0x44 and 0x9C and to unmapped offsets change nothing.
- R12: After reset, both queues are empty, both doorbells are clear, `irq` is low and the mask reads 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_req | input | 1 | Host access strobe, one cycle per access |
| hst_we | input | 1 | 1 = write, 0 = read |
| hst_addr | input | ADDR_W | Byte offset of the register |
| hst_wdata | input | DATA_W | Write data |
| hst_rvalid | output | 1 | Read data valid, one cycle after a read request |
| hst_rdata | output | DATA_W | Read data |
| irq | output | 1 | Interrupt to the host |
| dev_cmd_valid | output | 1 | Inbound queue holds a command |
| dev_cmd_addr | output | DATA_W | Oldest posted command address |
| dev_cmd_pop | input | 1 | Remove the oldest posted command |
| dev_ipq_ovf | output | 1 | Sticky inbound overflow flag |
| dev_cmp_push | input | 1 | Push a completion |
| dev_cmp_tag | input | DATA_W | Completion tag |
| dev_cmp_err | input | 1 | Error flag for this completion |
| dev_cmp_full | output | 1 | Outbound queue full |
| dev_odb_set | input | 1 | Raise the outbound doorbell |
| dev_cfg_update | output | 1 | Inbound doorbell (configuration changed) pending |
| dev_cfg_ack | input | 1 | Acknowledge the inbound doorbell |

## Verification
The bench builds the block with `NE_ALT`=1 and the default 16-entry queues. With `NE_ALT`=1, the not-empty flag appears at status bit 2 rather than the default bit 3, so a wrong variant selection shows up in every status read. A depth of 16 lets a short loop of 17 pushes reach the full condition of both queues. That brings the dropped-push, sticky-overflow and full-drain-to-sentinel cases within reach in a few hundred cycles.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

    // Register offsets; the host-side software depends on these positions.
    localparam logic [7:0] OFS_IDBR = 8'h20;  // inbound doorbell
    localparam logic [7:0] OFS_ISR  = 8'h30;  // interrupt status (raw)
    localparam logic [7:0] OFS_IMR  = 8'h34;  // interrupt mask
    localparam logic [7:0] OFS_IPQ  = 8'h40;  // inbound post queue
    localparam logic [7:0] OFS_OPQ  = 8'h44;  // outbound post queue
    localparam logic [7:0] OFS_OSR  = 8'h9c;  // outbound status
    localparam logic [7:0] OFS_ODC  = 8'ha0;  // outbound doorbell clear

    typedef enum logic {
        ACC_IDLE = 1'b0,
        ACC_RESP = 1'b1
    } acc_state_e;

    typedef enum logic {
        BELL_IDLE = 1'b0,
        BELL_PEND = 1'b1
    } bell_state_e;

endpackage

// File: rtl/cmdq_fifo.sv
module cmdq_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] pdata,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full,
    output logic [CNT_W-1:0] count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] cnt_q;
    logic             do_push;
    logic             do_pop;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign count   = cnt_q;
    assign head    = mem[rd_ptr];
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= pdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
            end
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + CNT_W'(1);
                2'b01:   cnt_q <= cnt_q - CNT_W'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    AST_FIFO_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH)); // R10
    AST_FIFO_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (full && $stable(count))); // R10
    AST_FIFO_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> empty); // R3

endmodule

// File: rtl/cmdq_bell.sv
module cmdq_bell
    import cmdq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic pend
);
    bell_state_e state_q;
    bell_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BELL_IDLE: if (set && !clr) state_d = BELL_PEND;
            BELL_PEND: if (clr)         state_d = BELL_IDLE;
            default:                    state_d = BELL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BELL_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        pend = (state_q == BELL_PEND);
    end

    AST_BELL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !clr) |=> pend); // R7
    AST_BELL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && clr) |=> !pend); // R8

endmodule

// File: rtl/cmdq_regblock.sv
module cmdq_regblock
    import cmdq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int QDEPTH = 16,
    parameter int NE_ALT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hst_req,
    input  logic              hst_we,
    input  logic [ADDR_W-1:0] hst_addr,
    input  logic [DATA_W-1:0] hst_wdata,
    output logic              hst_rvalid,
    output logic [DATA_W-1:0] hst_rdata,
    output logic              irq,
    output logic              dev_cmd_valid,
    output logic [DATA_W-1:0] dev_cmd_addr,
    input  logic              dev_cmd_pop,
    output logic              dev_ipq_ovf,
    input  logic              dev_cmp_push,
    input  logic [DATA_W-1:0] dev_cmp_tag,
    input  logic              dev_cmp_err,
    output logic              dev_cmp_full,
    input  logic              dev_odb_set,
    output logic              dev_cfg_update,
    input  logic              dev_cfg_ack
);
    localparam int CNT_W  = $clog2(QDEPTH + 1);
    localparam int NE_BIT = (NE_ALT != 0) ? 2 : 3;

    // decode
    logic wr, rd;
    logic hit_idbr, hit_isr, hit_imr, hit_ipq, hit_opq, hit_osr, hit_odc;

    assign wr       = hst_req && hst_we;
    assign rd       = hst_req && !hst_we;
    assign hit_idbr = (hst_addr == ADDR_W'(OFS_IDBR));
    assign hit_isr  = (hst_addr == ADDR_W'(OFS_ISR));
    assign hit_imr  = (hst_addr == ADDR_W'(OFS_IMR));
    assign hit_ipq  = (hst_addr == ADDR_W'(OFS_IPQ));
    assign hit_opq  = (hst_addr == ADDR_W'(OFS_OPQ));
    assign hit_osr  = (hst_addr == ADDR_W'(OFS_OSR));
    assign hit_odc  = (hst_addr == ADDR_W'(OFS_ODC));

    // inbound queue
    logic             ipq_empty, ipq_full, ipq_push;
    logic [CNT_W-1:0] ipq_count;

    assign ipq_push = wr && hit_ipq;

    cmdq_fifo #(.WIDTH(DATA_W), .DEPTH(QDEPTH), .CNT_W(CNT_W)) u_ipq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (ipq_push),
        .pdata (hst_wdata),
        .pop   (dev_cmd_pop),
        .head  (dev_cmd_addr),
        .empty (ipq_empty),
        .full  (ipq_full),
        .count (ipq_count)
    );

    assign dev_cmd_valid = !ipq_empty;

    // outbound queue
    logic              opq_empty, opq_full, opq_pop;
    logic [CNT_W-1:0]  opq_count;
    logic [DATA_W-1:0] opq_head;
    logic [DATA_W-1:0] cmp_word;

    always_comb begin
        cmp_word    = dev_cmp_tag;
        cmp_word[1] = dev_cmp_err;
        cmp_word[0] = 1'b0;
    end

    assign opq_pop = rd && hit_opq;

    cmdq_fifo #(.WIDTH(DATA_W), .DEPTH(QDEPTH), .CNT_W(CNT_W)) u_opq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (dev_cmp_push),
        .pdata (cmp_word),
        .pop   (opq_pop),
        .head  (opq_head),
        .empty (opq_empty),
        .full  (opq_full),
        .count (opq_count)
    );

    assign dev_cmp_full = opq_full;

    // doorbells
    logic ob_pend;

    cmdq_bell u_ibell (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (wr && hit_idbr && hst_wdata[0]),
        .clr   (dev_cfg_ack),
        .pend  (dev_cfg_update)
    );

    cmdq_bell u_obell (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (dev_odb_set),
        .clr   (wr && hit_odc && hst_wdata[0]),
        .pend  (ob_pend)
    );

    // mask, overflow, status
    logic [DATA_W-1:0] mask_q;
    logic              ovf_q;
    logic [DATA_W-1:0] isr_raw;
    logic [DATA_W-1:0] osr_val;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
            ovf_q  <= 1'b0;
        end else begin
            if (wr && hit_imr) mask_q <= hst_wdata;
            if (ipq_push && ipq_full) ovf_q <= 1'b1;
        end
    end

    assign dev_ipq_ovf = ovf_q;

    always_comb begin
        isr_raw         = '0;
        isr_raw[NE_BIT] = !opq_empty;
        isr_raw[0]      = ob_pend;
    end

    always_comb begin
        osr_val           = '0;
        osr_val[0 +: CNT_W] = opq_count;
        osr_val[8 +: CNT_W] = ipq_count;
        osr_val[16]       = ob_pend;
    end

    // read mux
    logic [DATA_W-1:0] rd_mux;

    always_comb begin
        rd_mux = '0;
        if (hit_idbr)     rd_mux[0] = dev_cfg_update;
        else if (hit_isr) rd_mux    = isr_raw;
        else if (hit_imr) rd_mux    = mask_q;
        else if (hit_opq) rd_mux    = opq_empty ? '1 : opq_head;
        else if (hit_osr) rd_mux    = osr_val;
    end

    // access state machine
    acc_state_e        acc_q;
    acc_state_e        acc_d;
    logic [DATA_W-1:0] rdata_q;
    logic              irq_q;

    always_comb begin
        acc_d = acc_q;
        unique case (acc_q)
            ACC_IDLE: if (rd)  acc_d = ACC_RESP;
            ACC_RESP: if (!rd) acc_d = ACC_IDLE;
            default:           acc_d = ACC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= ACC_IDLE;
            rdata_q <= '0;
            irq_q   <= 1'b0;
        end else begin
            acc_q <= acc_d;
            if (rd) rdata_q <= rd_mux;
            irq_q <= |(isr_raw & ~mask_q);
        end
    end

    always_comb begin
        hst_rvalid = (acc_q == ACC_RESP);
        hst_rdata  = rdata_q;
        irq        = irq_q;
    end

    AST_EMPTY_SENTINEL: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && hit_opq && opq_empty) |=> (hst_rdata == '1)); // R3
    AST_READ_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> hst_rvalid); // R2
    AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mask_q) == '1) |-> !irq); // R6
    AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (!opq_empty && !mask_q[NE_BIT]) |=> irq); // R6
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        dev_ipq_ovf |=> dev_ipq_ovf); // R10
    AST_IPQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (ipq_push && ipq_full && !dev_cmd_pop) |=> (dev_ipq_ovf && dev_cmd_valid)); // R10

endmodule

// File: tb/sim_cmdq_regblock.sv
module sim_cmdq_regblock;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hst_req = 1'b0;
    logic        hst_we = 1'b0;
    logic [7:0]  hst_addr = '0;
    logic [31:0] hst_wdata = '0;
    logic        hst_rvalid;
    logic [31:0] hst_rdata;
    logic        irq;
    logic        dev_cmd_valid;
    logic [31:0] dev_cmd_addr;
    logic        dev_cmd_pop = 1'b0;
    logic        dev_ipq_ovf;
    logic        dev_cmp_push = 1'b0;
    logic [31:0] dev_cmp_tag = '0;
    logic        dev_cmp_err = 1'b0;
    logic        dev_cmp_full;
    logic        dev_odb_set = 1'b0;
    logic        dev_cfg_update;
    logic        dev_cfg_ack = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    bit reported = 1'b0;

    always #5 clk = ~clk;

    cmdq_regblock #(.ADDR_W(8), .DATA_W(32), .QDEPTH(16), .NE_ALT(1)) u0 (
        .clk(clk), .rst_n(rst_n),
        .hst_req(hst_req), .hst_we(hst_we), .hst_addr(hst_addr), .hst_wdata(hst_wdata),
        .hst_rvalid(hst_rvalid), .hst_rdata(hst_rdata), .irq(irq),
        .dev_cmd_valid(dev_cmd_valid), .dev_cmd_addr(dev_cmd_addr), .dev_cmd_pop(dev_cmd_pop),
        .dev_ipq_ovf(dev_ipq_ovf), .dev_cmp_push(dev_cmp_push), .dev_cmp_tag(dev_cmp_tag),
        .dev_cmp_err(dev_cmp_err), .dev_cmp_full(dev_cmp_full), .dev_odb_set(dev_odb_set),
        .dev_cfg_update(dev_cfg_update), .dev_cfg_ack(dev_cfg_ack)
    );

    typedef struct packed {
        logic        we;
        logic [7:0]  a;
        logic [31:0] d;
        logic [31:0] e;
        logic [7:0]  rq;
    } vec_t;

    // Reset values (R12), unmapped/read-only (R11), mask (R6), inbound doorbell (R7), sentinel (R3)
    localparam int NV = 18;
    localparam vec_t VT [NV] = '{
        '{1'b0, 8'h34, 32'h0,        32'hFFFF_FFFF, 8'd12},
        '{1'b0, 8'h30, 32'h0,        32'h0,         8'd12},
        '{1'b0, 8'h44, 32'h0,        32'hFFFF_FFFF, 8'd3},
        '{1'b0, 8'h20, 32'h0,        32'h0,         8'd12},
        '{1'b0, 8'h9c, 32'h0,        32'h0,         8'd12},
        '{1'b0, 8'h10, 32'h0,        32'h0,         8'd11},
        '{1'b1, 8'h10, 32'hDEAD_BEEF, 32'h0,        8'd11},
        '{1'b0, 8'h10, 32'h0,        32'h0,         8'd11},
        '{1'b1, 8'h34, 32'h0,        32'h0,         8'd6},
        '{1'b0, 8'h34, 32'h0,        32'h0,         8'd6},
        '{1'b1, 8'h30, 32'hFFFF_FFFF, 32'h0,        8'd11},
        '{1'b0, 8'h30, 32'h0,        32'h0,         8'd11},
        '{1'b1, 8'h20, 32'h1,        32'h0,         8'd7},
        '{1'b0, 8'h20, 32'h0,        32'h1,         8'd7},
        '{1'b1, 8'h20, 32'h0,        32'h0,         8'd7},
        '{1'b0, 8'h20, 32'h0,        32'h1,         8'd7},
        '{1'b1, 8'h9c, 32'h55,       32'h0,         8'd11},
        '{1'b0, 8'h9c, 32'h0,        32'h0,         8'd11}
    };

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic host_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        hst_req = 1'b1; hst_we = 1'b1; hst_addr = a; hst_wdata = d;
        @(negedge clk);
        hst_req = 1'b0; hst_we = 1'b0;
    endtask

    task automatic host_read(input logic [7:0] a, output logic [31:0] d, output logic v);
        @(negedge clk);
        hst_req = 1'b1; hst_we = 1'b0; hst_addr = a;
        @(negedge clk);
        hst_req = 1'b0;
        d = hst_rdata;
        v = hst_rvalid;
    endtask

    task automatic dev_push(input logic [31:0] t, input logic e);
        @(negedge clk);
        dev_cmp_push = 1'b1; dev_cmp_tag = t; dev_cmp_err = e;
        @(negedge clk);
        dev_cmp_push = 1'b0;
    endtask

    task automatic report;
        if (!reported) begin
            reported = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        logic [31:0] rd;
        logic        v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset outputs
        check("R12", {28'h0, irq, dev_cmd_valid, dev_cfg_update, dev_ipq_ovf}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VT[i].we) begin
                host_write(VT[i].a, VT[i].d);
            end else begin
                host_read(VT[i].a, rd, v);
                check($sformatf("R%0d", VT[i].rq), rd, VT[i].e);
            end
        end

        // R7: device sees the doorbell, ack clears it
        check("R7", {31'h0, dev_cfg_update}, 32'h1);
        @(negedge clk); dev_cfg_ack = 1'b1;
        @(negedge clk); dev_cfg_ack = 1'b0;
        check("R7", {31'h0, dev_cfg_update}, 32'h0);
        host_read(8'h20, rd, v);
        check("R7", rd, 32'h0);

        // R4/R2/R5/R6/R9: completions
        dev_push(32'h0000_1000, 1'b0);
        dev_push(32'h0000_2004, 1'b1);
        dev_push(32'h0000_3003, 1'b0);
        @(negedge clk);
        check("R6", {31'h0, irq}, 32'h1);
        host_read(8'h30, rd, v);
        check("R5", rd, 32'h4);
        host_read(8'h9c, rd, v);
        check("R9", rd, 32'h3);
        host_write(8'h34, 32'h4);
        @(negedge clk);
        check("R6", {31'h0, irq}, 32'h0);
        host_read(8'h30, rd, v);
        check("R5", rd, 32'h4);
        host_write(8'h34, 32'h0);
        host_write(8'h44, 32'h0);   // R11: write to outbound queue ignored
        host_read(8'h44, rd, v);
        check("R2", {31'h0, v}, 32'h1);
        check("R2", rd, 32'h0000_1000);
        host_read(8'h44, rd, v);
        check("R4", rd, 32'h0000_2006);
        host_read(8'h44, rd, v);
        check("R4", rd, 32'h0000_3000);
        host_read(8'h44, rd, v);
        check("R3", rd, 32'hFFFF_FFFF);
        @(negedge clk);
        check("R6", {31'h0, irq}, 32'h0);
        host_read(8'h30, rd, v);
        check("R3", rd, 32'h0);

        // R1/R10: inbound queue order and overflow
        for (int i = 0; i < 16; i++) host_write(8'h40, 32'h100 + 32'(i) * 4);
        check("R10", {31'h0, dev_ipq_ovf}, 32'h0);
        host_read(8'h9c, rd, v);
        check("R9", rd, 32'h0000_1000);
        host_write(8'h40, 32'hBAD0);
        check("R10", {31'h0, dev_ipq_ovf}, 32'h1);
        for (int i = 0; i < 16; i++) begin
            check("R1", {31'h0, dev_cmd_valid}, 32'h1);
            check("R1", dev_cmd_addr, 32'h100 + 32'(i) * 4);
            @(negedge clk); dev_cmd_pop = 1'b1;
            @(negedge clk); dev_cmd_pop = 1'b0;
        end
        check("R1", {31'h0, dev_cmd_valid}, 32'h0);
        check("R10", {31'h0, dev_ipq_ovf}, 32'h1);

        // R8: outbound doorbell
        @(negedge clk); dev_odb_set = 1'b1;
        @(negedge clk); dev_odb_set = 1'b0;
        @(negedge clk);
        check("R8", {31'h0, irq}, 32'h1);
        host_read(8'h30, rd, v);
        check("R8", rd, 32'h1);
        host_read(8'h9c, rd, v);
        check("R9", rd, 32'h0001_0000);
        host_write(8'ha0, 32'h2);
        host_read(8'h30, rd, v);
        check("R8", rd, 32'h1);
        host_write(8'ha0, 32'h1);
        host_read(8'h30, rd, v);
        check("R8", rd, 32'h0);

        // R10: outbound full, drop, drain to sentinel
        for (int i = 0; i < 17; i++) dev_push(32'(i + 1) * 32'h40, 1'b0);
        check("R10", {31'h0, dev_cmp_full}, 32'h1);
        host_read(8'h9c, rd, v);
        check("R10", rd, 32'h10);
        for (int i = 0; i < 16; i++) begin
            host_read(8'h44, rd, v);
            check("R10", rd, 32'(i + 1) * 32'h40);
        end
        host_read(8'h44, rd, v);
        check("R3", rd, 32'hFFFF_FFFF);
        check("R10", {31'h0, dev_cmp_full}, 32'h0);

        // R12: reset restores the mask and clears the sticky flag
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        host_read(8'h34, rd, v);
        check("R12", rd, 32'hFFFF_FFFF);
        check("R12", {31'h0, dev_ipq_ovf}, 32'h0);

        report();
    end

endmodule